// File: doc/BRIEF.md
# Frame Receive FIFO Overflow Tracker

This block connects a frame receiver to the receive FIFO that a host drains. It accepts a byte stream with a start marker on the first data byte of each frame and a separate end beat that carries the receiver's verdict on the frame. Data bytes go into a 32-entry FIFO. Each entry is 9 bits wide: a data byte plus a marker bit that tells status bytes apart from data. When a frame ends, a status byte is placed behind its data. The status byte records whether the frame was good and whether any of its bytes were lost.

The FIFO can fill while a frame is arriving. Bytes are then dropped only while no room is left, and storage picks up again in the middle of the frame as soon as the host frees space. The block keeps two sticky interrupt flags. The first reports that a stored frame lost part of its data. The second reports that a whole frame, or one character in character mode, was thrown away. The host clears either flag with a write-one-to-clear strobe. A one-cycle status pulse gives a DMA side the stored byte count and the loss bit of every frame whose status byte was written.

A mode input selects the behaviour. In frame mode, frames carry status bytes and the last FIFO entry is kept in reserve. In character mode, each received byte is a character, stored without a status byte, and the whole FIFO depth is available.

Top module: `rxovf_tracker`

## Requirements
- R1: In frame mode, a data byte is written, in arrival order, only while the FIFO holds fewer than DEPTH-1 entries. The last entry is kept for the status byte.
- R2: In frame mode, an end beat writes one status entry with the marker bit at 1, provided the FIFO holds fewer than DEPTH entries. Bit 7 of that entry copies the frame-ok input, bit 5 is set if the frame lost any byte, and all other bits are 0.
- R3: A data byte that arrives when no room is left is dropped and the frame is marked as lossy. Later bytes of the same frame are stored again once host reads have freed space.
- R4: The data-overflow flag is set in the cycle the status byte of a lossy frame is written. It is not set earlier.
- R5: If the FIFO holds DEPTH entries at an end beat in frame mode, the frame is discarded. No status entry is written, no DMA pulse is produced, the FIFO-overflow flag is set, and the data-overflow flag is left unchanged.
- R6: In character mode, each data beat is stored with the marker bit at 0 while the FIFO holds fewer than DEPTH entries. Otherwise the character is dropped and the FIFO-overflow flag is set. End beats and start markers have no effect.
- R7: Both flags are sticky. Bit 0 of the clear strobe clears data overflow and bit 1 clears FIFO overflow. A set in the same cycle as a clear wins.
- R8: One cycle after each written status byte, the DMA status pulse is high for one cycle. It carries the number of data bytes stored for that frame and the frame's loss bit.
- R9: A read request while the FIFO is not empty returns the oldest entry one cycle later, with valid high. A read request while the FIFO is empty returns nothing. The empty and full outputs follow the number of stored entries.
- R10: After reset the FIFO is empty, both flags are clear, and the valid and DMA pulse outputs are low.
- R11: A data beat that carries the start marker begins a new frame, clearing the loss state and the byte count of the frame before it. If a data beat and an end beat arrive together, the data beat is used and the end beat is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_mode_i | input | 1 | 1 = character mode, 0 = frame mode |
| in_valid_i | input | 1 | Data beat present |
| in_sof_i | input | 1 | Data beat is the first byte of a frame |
| in_byte_i | input | 8 | Received byte |
| in_end_i | input | 1 | End-of-frame beat |
| in_frame_ok_i | input | 1 | Receiver verdict, sampled on the end beat |
| rd_en_i | input | 1 | Host read request |
| rd_valid_o | output | 1 | Read data valid |
| rd_byte_o | output | 8 | Read data byte |
| rd_is_status_o | output | 1 | Read entry is a status byte |
| fifo_empty_o | output | 1 | FIFO holds no entry |
| fifo_full_o | output | 1 | FIFO holds DEPTH entries |
| irq_clr_i | input | 2 | Write-one-to-clear: bit 0 data overflow, bit 1 FIFO overflow |
| irq_data_ovf_o | output | 1 | Sticky partial-loss flag |
| irq_fifo_ovf_o | output | 1 | Sticky discarded-frame/character flag |
| frm_stat_valid_o | output | 1 | Per-frame DMA status pulse |
| frm_byte_cnt_o | output | FCNT_W | Data bytes stored for the frame |
| frm_data_ovf_o | output | 1 | Frame lost data |

## Verification
A host clear and a new overflow event can fall in the same cycle. The bench provokes this by sending a character into a full FIFO in character mode while the FIFO-overflow clear bit is high. It then checks that the flag stays set, and that a clear on its own in the following beat removes it. Host reads and frame bytes can also overlap at the full boundary. A frame is filled past the reserve limit, three entries are drained, and the rest of the frame is sent. The scoreboard then expects exactly the bytes that fit back into the FIFO, followed by a status byte with the loss bit set.

// File: rtl/rxovf_pkg.sv
package rxovf_pkg;
    localparam int BYTE_W        = 8;
    localparam int STAT_OK_BIT   = 7;
    localparam int STAT_LOSS_BIT = 5;
    localparam int FLAG_DOVF     = 0;
    localparam int FLAG_FOVF     = 1;
    localparam int NUM_FLAGS     = 2;

    typedef struct packed {
        logic              mark;
        logic [BYTE_W-1:0] data;
    } fifo_word_t;
endpackage

// File: rtl/rxovf_fifo.sv
module rxovf_fifo
    import rxovf_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  fifo_word_t    wr_word_i,
    input  logic          rd_i,
    output fifo_word_t    rd_word_o,
    output logic          rd_valid_o,
    output logic [CW-1:0] cnt_o,
    output logic          full_o,
    output logic          empty_o
);
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
        logic          rvalid;
        fifo_word_t    rword;
    } fifo_st_t;

    fifo_st_t   st_d, st_q;
    fifo_word_t mem_q [DEPTH];
    logic       do_rd, do_wr;

    always_comb begin
        st_d   = st_q;
        do_rd  = rd_i && (st_q.cnt != '0);
        do_wr  = wr_i && (st_q.cnt != FULL_LVL);
        st_d.rvalid = do_rd;
        if (do_rd) begin
            st_d.rword = mem_q[st_q.rptr];
            st_d.rptr  = (st_q.rptr == LAST_IDX) ? '0 : st_q.rptr + AW'(1);
        end
        if (do_wr) begin
            st_d.wptr = (st_q.wptr == LAST_IDX) ? '0 : st_q.wptr + AW'(1);
        end
        case ({do_wr, do_rd})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem_q[st_q.wptr] <= wr_word_i;
    end

    assign rd_word_o  = st_q.rword;
    assign rd_valid_o = st_q.rvalid;
    assign cnt_o      = st_q.cnt;
    assign full_o     = (st_q.cnt == FULL_LVL);
    assign empty_o    = (st_q.cnt == '0);

    // R9
    no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> (st_q.cnt != FULL_LVL));

    // R9
    read_valid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rvalid |-> ($past(rd_i) && ($past(st_q.cnt) != '0)));
endmodule

// File: rtl/rxovf_flags.sv
module rxovf_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_d, flag_q;

    always_comb begin
        flag_d = (flag_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    for (genvar i = 0; i < N; i++) begin : g_flag_chk
        // R7
        flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr_i[i]) |=> flag_q[i]);
        // R7
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_q[i]);
    end
endmodule

// File: rtl/rxovf_ctrl.sv
module rxovf_ctrl
    import rxovf_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int FCNT_W = 12,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_mode_i,
    input  logic              in_valid_i,
    input  logic              in_sof_i,
    input  logic [BYTE_W-1:0] in_byte_i,
    input  logic              in_end_i,
    input  logic              in_frame_ok_i,
    input  logic [CW-1:0]     cnt_i,
    output logic              wr_o,
    output fifo_word_t        wr_word_o,
    output logic [NUM_FLAGS-1:0] set_o,
    output logic              frm_valid_o,
    output logic [FCNT_W-1:0] frm_cnt_o,
    output logic              frm_loss_o
);
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
    localparam logic [CW-1:0] DATA_LIM = CW'(DEPTH - 1);

    typedef struct packed {
        logic              loss;
        logic [FCNT_W-1:0] fcnt;
        logic              fv;
        logic [FCNT_W-1:0] fc;
        logic              fl;
    } ctrl_st_t;

    ctrl_st_t          st_d, st_q;
    logic              base_loss;
    logic [FCNT_W-1:0] base_cnt;

    always_comb begin
        st_d      = st_q;
        st_d.fv   = 1'b0;
        wr_o      = 1'b0;
        wr_word_o = '0;
        set_o     = '0;
        base_loss = in_sof_i ? 1'b0 : st_q.loss;
        base_cnt  = in_sof_i ? '0 : st_q.fcnt;
        if (char_mode_i) begin
            if (in_valid_i) begin
                if (cnt_i < FULL_LVL) begin
                    wr_o           = 1'b1;
                    wr_word_o.data = in_byte_i;
                end else begin
                    set_o[FLAG_FOVF] = 1'b1;
                end
            end
        end else if (in_valid_i) begin
            if (cnt_i < DATA_LIM) begin
                wr_o           = 1'b1;
                wr_word_o.data = in_byte_i;
                st_d.fcnt      = base_cnt + FCNT_W'(1);
                st_d.loss      = base_loss;
            end else begin
                st_d.fcnt      = base_cnt;
                st_d.loss      = 1'b1;
            end
        end else if (in_end_i) begin
            if (cnt_i < FULL_LVL) begin
                wr_o                          = 1'b1;
                wr_word_o.mark                = 1'b1;
                wr_word_o.data[STAT_OK_BIT]   = in_frame_ok_i;
                wr_word_o.data[STAT_LOSS_BIT] = st_q.loss;
                set_o[FLAG_DOVF]              = st_q.loss;
                st_d.fv                       = 1'b1;
                st_d.fc                       = st_q.fcnt;
                st_d.fl                       = st_q.loss;
            end else begin
                set_o[FLAG_FOVF] = 1'b1;
            end
            st_d.loss = 1'b0;
            st_d.fcnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frm_valid_o = st_q.fv;
    assign frm_cnt_o   = st_q.fc;
    assign frm_loss_o  = st_q.fl;
endmodule

// File: rtl/rxovf_tracker.sv
module rxovf_tracker
    import rxovf_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int FCNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_mode_i,
    input  logic              in_valid_i,
    input  logic              in_sof_i,
    input  logic [7:0]        in_byte_i,
    input  logic              in_end_i,
    input  logic              in_frame_ok_i,
    input  logic              rd_en_i,
    output logic              rd_valid_o,
    output logic [7:0]        rd_byte_o,
    output logic              rd_is_status_o,
    output logic              fifo_empty_o,
    output logic              fifo_full_o,
    input  logic [1:0]        irq_clr_i,
    output logic              irq_data_ovf_o,
    output logic              irq_fifo_ovf_o,
    output logic              frm_stat_valid_o,
    output logic [FCNT_W-1:0] frm_byte_cnt_o,
    output logic              frm_data_ovf_o
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] DATA_LIM = CW'(DEPTH - 1);

    logic                 wr;
    fifo_word_t           wr_word, rd_word;
    logic [CW-1:0]        cnt;
    logic [NUM_FLAGS-1:0] flag_set, flags;

    rxovf_ctrl #(.DEPTH(DEPTH), .FCNT_W(FCNT_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .char_mode_i   (char_mode_i),
        .in_valid_i    (in_valid_i),
        .in_sof_i      (in_sof_i),
        .in_byte_i     (in_byte_i),
        .in_end_i      (in_end_i),
        .in_frame_ok_i (in_frame_ok_i),
        .cnt_i         (cnt),
        .wr_o          (wr),
        .wr_word_o     (wr_word),
        .set_o         (flag_set),
        .frm_valid_o   (frm_stat_valid_o),
        .frm_cnt_o     (frm_byte_cnt_o),
        .frm_loss_o    (frm_data_ovf_o)
    );

    rxovf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr),
        .wr_word_i  (wr_word),
        .rd_i       (rd_en_i),
        .rd_word_o  (rd_word),
        .rd_valid_o (rd_valid_o),
        .cnt_o      (cnt),
        .full_o     (fifo_full_o),
        .empty_o    (fifo_empty_o)
    );

    rxovf_flags #(.N(NUM_FLAGS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set),
        .clr_i  (irq_clr_i),
        .flag_o (flags)
    );

    assign rd_byte_o      = rd_word.data;
    assign rd_is_status_o = rd_word.mark;
    assign irq_data_ovf_o = flags[FLAG_DOVF];
    assign irq_fifo_ovf_o = flags[FLAG_FOVF];

    // R1
    reserve_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!char_mode_i && wr && !wr_word.mark) |-> (cnt < DATA_LIM));

    // R5
    discard_no_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!char_mode_i && in_end_i && !in_valid_i && fifo_full_o) |=> !frm_stat_valid_o);

    // R6
    char_no_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_mode_i && wr) |-> !wr_word.mark);

    // R8
    dma_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_stat_valid_o |=> !frm_stat_valid_o);
endmodule

// File: tb/tb_rxovf_tracker.sv
`timescale 1ns/1ps
module tb_rxovf_tracker;
    localparam int DEPTH  = 32;
    localparam int FCNT_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic char_mode_i = 1'b0, in_valid_i = 1'b0, in_sof_i = 1'b0, in_end_i = 1'b0;
    logic in_frame_ok_i = 1'b0, rd_en_i = 1'b0;
    logic [7:0] in_byte_i = '0;
    logic [1:0] irq_clr_i = '0;
    logic rd_valid_o, rd_is_status_o, fifo_empty_o, fifo_full_o;
    logic irq_data_ovf_o, irq_fifo_ovf_o, frm_stat_valid_o, frm_data_ovf_o;
    logic [7:0] rd_byte_o;
    logic [FCNT_W-1:0] frm_byte_cnt_o;

    always #4 clk = ~clk;

    rxovf_tracker #(.DEPTH(DEPTH), .FCNT_W(FCNT_W)) dut (.*);

    int n_chk = 0, n_fail = 0;
    logic [8:0] exp_q [$];
    int occ = 0, fcnt = 0;
    bit loss = 0, e_dovf = 0, e_fovf = 0, done = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_flags(string req);
        chk(irq_data_ovf_o == e_dovf, req, "data overflow flag", irq_data_ovf_o, e_dovf);
        chk(irq_fifo_ovf_o == e_fovf, req, "fifo overflow flag", irq_fifo_ovf_o, e_fovf);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid_o) begin
            if (exp_q.size() == 0) begin
                chk(0, "R9", "unexpected read entry", {rd_is_status_o, rd_byte_o}, 0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk({rd_is_status_o, rd_byte_o} == e, "R1/R2 (R9 order)", "read entry",
                    {rd_is_status_o, rd_byte_o}, e);
            end
        end
    end

    task automatic beat_byte(input logic [7:0] d, input bit sof, input logic [1:0] clr = 2'b00);
        @(negedge clk);
        in_valid_i = 1'b1; in_sof_i = sof; in_byte_i = d; irq_clr_i = clr;
        if (clr[0]) e_dovf = 0;
        if (clr[1]) e_fovf = 0;
        if (char_mode_i) begin
            if (occ < DEPTH) begin exp_q.push_back({1'b0, d}); occ++; end
            else e_fovf = 1;
        end else begin
            if (sof) begin loss = 0; fcnt = 0; end
            if (occ < DEPTH - 1) begin exp_q.push_back({1'b0, d}); occ++; fcnt++; end
            else loss = 1;
        end
        @(posedge clk); #1;
        in_valid_i = 1'b0; in_sof_i = 1'b0; irq_clr_i = '0;
        chk_flags("R4/R6/R7");
        chk(frm_stat_valid_o == 1'b0, "R8", "no pulse after data beat", frm_stat_valid_o, 0);
    endtask

    task automatic beat_end(input bit ok);
        bit wrote;
        @(negedge clk);
        in_end_i = 1'b1; in_frame_ok_i = ok;
        wrote = 0;
        if (!char_mode_i) begin
            if (occ < DEPTH) begin
                exp_q.push_back({1'b1, ok, 1'b0, loss, 5'b0}); occ++;
                if (loss) e_dovf = 1;
                wrote = 1;
            end else e_fovf = 1;
        end
        @(posedge clk); #1;
        in_end_i = 1'b0; in_frame_ok_i = 1'b0;
        chk_flags("R4/R5");
        chk(frm_stat_valid_o == wrote, "R8", "DMA pulse", frm_stat_valid_o, wrote);
        if (wrote) begin
            chk(frm_byte_cnt_o == FCNT_W'(fcnt), "R8", "DMA byte count", frm_byte_cnt_o, fcnt);
            chk(frm_data_ovf_o == loss, "R8", "DMA loss bit", frm_data_ovf_o, loss);
        end
        if (!char_mode_i) begin loss = 0; fcnt = 0; end
    endtask

    task automatic do_read(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_en_i = 1'b1;
            @(posedge clk); #1;
            rd_en_i = 1'b0;
            if (occ > 0) occ--;
        end
    endtask

    task automatic do_clear(input logic [1:0] m);
        @(negedge clk);
        irq_clr_i = m;
        if (m[0]) e_dovf = 0;
        if (m[1]) e_fovf = 0;
        @(posedge clk); #1;
        irq_clr_i = '0;
        chk_flags("R7");
    endtask

    task automatic chk_level(string tag);
        chk(fifo_full_o == (occ == DEPTH), "R9", {tag, " full"}, fifo_full_o, occ == DEPTH);
        chk(fifo_empty_o == (occ == 0), "R9", {tag, " empty"}, fifo_empty_o, occ == 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(fifo_empty_o == 1, "R10", "empty after reset", fifo_empty_o, 1);
        chk(fifo_full_o == 0, "R10", "full after reset", fifo_full_o, 0);
        chk(rd_valid_o == 0 && frm_stat_valid_o == 0, "R10", "pulses after reset",
            {rd_valid_o, frm_stat_valid_o}, 0);
        chk_flags("R10");

        // R1 R2: two clean frames, good and bad verdict
        for (int i = 0; i < 5; i++) beat_byte(8'h10 + 8'(i), i == 0);
        beat_end(1);
        for (int i = 0; i < 2; i++) beat_byte(8'hC0 + 8'(i), i == 0);
        beat_end(0);
        do_read(9);
        repeat (2) @(negedge clk);
        chk_level("R9 drained");

        // R1 R3 R4: long frame from empty, tail dropped, reserve keeps status
        for (int i = 0; i < 40; i++) begin
            beat_byte(8'(i), i == 0);
            if (i == 30) chk(fifo_full_o == 0, "R1", "reserve slot free", fifo_full_o, 0);
        end
        beat_end(1);
        chk_level("R2 status in reserve");

        // R5: whole frame discarded into a full FIFO
        for (int i = 0; i < 3; i++) beat_byte(8'hE0 + 8'(i), i == 0);
        beat_end(1);
        chk_level("R5 still full");
        do_read(DEPTH);
        repeat (2) @(negedge clk);
        do_clear(2'b11);

        // R3: storage resumes mid-frame after reads
        for (int i = 0; i < 33; i++) beat_byte(8'h40 + 8'(i), i == 0);
        do_read(3);
        for (int i = 0; i < 4; i++) beat_byte(8'h80 + 8'(i), 1'b0);
        beat_end(1);
        do_read(occ);
        repeat (2) @(negedge clk);

        // R11: start marker abandons a lossy partial frame
        do_clear(2'b01);
        for (int i = 0; i < 31; i++) beat_byte(8'h20 + 8'(i), i == 0);
        beat_byte(8'h55, 1'b0);
        do_read(occ);
        beat_byte(8'h66, 1'b1);
        beat_byte(8'h67, 1'b0);
        beat_end(1);
        do_read(occ);
        repeat (2) @(negedge clk);

        // R6 R7: character mode, full depth, clear colliding with set
        @(negedge clk); char_mode_i = 1'b1;
        for (int i = 0; i < DEPTH; i++) beat_byte(8'hA0 + 8'(i), i == 3);
        chk_level("R6 full depth");
        beat_byte(8'hFF, 1'b0, 2'b10);
        chk(irq_fifo_ovf_o == 1, "R7", "set wins over clear", irq_fifo_ovf_o, 1);
        beat_end(1);
        chk_level("R6 end beat ignored");
        do_clear(2'b10);
        do_read(DEPTH);
        repeat (2) @(negedge clk);
        chk_level("R6 drained");

        // R9: read of empty FIFO returns nothing
        do_read(1);
        @(negedge clk);
        chk(rd_valid_o == 0, "R9", "no data from empty", rd_valid_o, 0);
        chk(exp_q.size() == 0, "R9", "scoreboard drained", exp_q.size(), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule